// File: doc/BRIEF.md
# Strided Row-Copy DMA Engine

This engine copies a two-dimensional block of data between a small on-chip memory and a large external memory. The on-chip memory has two banks of 4 KB each. Bank 1 holds instructions and bank 0 holds data. Software programs three things through a word-indexed register port: a local address with a bank-select bit, an external byte address, and a length word. Writing the length word at one of two register slots starts a transfer. The slot that receives the write sets the direction.

A transfer moves `count+1` rows. Each row is `length+1` bytes rounded up to a whole number of 64-bit beats. After each row the external address jumps forward by an extra skip amount. The local address never skips, and it wraps inside its 4 KB bank. Local RAM reads have one cycle of latency. External beats use a valid/ready handshake, and read data returns in the same cycle as the accepted request.

When a transfer ends, the two address slots read back the addresses the engine reached. The length slot reads back a fixed idle pattern that keeps the skip field.

Top module: `rowcopy_dma`

## Requirements
- R1: After reset every register slot (index 0 to 4) reads 0, `busy` is low, and neither memory port is active.
- R2: A write to slot 1 (external address) keeps only bits 23:3, so its readback is the written value ANDed with 0xFFFFF8.
- R3: A write to slot 0 (local address) keeps byte-address bits 11:3 and the bank bit 12, so its readback is the written value ANDed with 0x1FF8.
- R4: When idle, a write to slot 2 starts an external-to-local transfer (local RAM writes only). A write to slot 3 starts a local-to-external transfer (external writes only).
- R5: The length word holds the length in bits 11:0, the count in bits 19:12 and the skip in bits 31:20. Each row is `length[11:3]+1` beats of 8 bytes. There are `count+1` rows, and every beat carries the right data.
- R6: The external address goes up by 8 after each beat. After the last beat of each row it goes up by a further `skip`.
- R7: The local word address goes up by one on each beat and wraps from word 511 to word 0 of the same bank. `loc_cs[1]` selects the instruction bank (bit 12 set) and `loc_cs[0]` selects the data bank. At most one bit is set.
- R8: After a transfer, slot 0 reads the final local address with its bank bit. Slot 1 reads the final external address ANDed with 0xFFFFF8.
- R9: After a transfer, slots 2 and 3 both read `{skip, 0x00, 0xFF8}`.
- R10: `busy` rises in the cycle after the triggering write. It falls in the cycle after the last beat is accepted. Register writes made while `busy` is high are ignored.
- R11: While `ext_valid` is high and `ext_ready` is low, `ext_valid`, `ext_write`, `ext_addr` and `ext_wdata` hold steady.
- R12: Slot 4 reads `busy` in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register slot (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| busy | output | 1 | Transfer in progress |
| loc_cs | output | 2 | Local bank selects (bit 1 instruction, bit 0 data) |
| loc_we | output | 1 | Local write enable |
| loc_addr | output | 9 | Local 64-bit word address within bank |
| loc_wdata | output | 64 | Local write data |
| loc_rdata | input | 64 | Local read data, one cycle after the select |
| ext_valid | output | 1 | External beat request |
| ext_ready | input | 1 | External beat accepted |
| ext_write | output | 1 | 1: write to external memory, 0: read |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 64 | External write data |
| ext_rdata | input | 64 | External read data, valid when the read beat is accepted |

## Verification
`busy` is sampled at the first falling edge after the edge that captures the length write, because the state register changes on that one edge. Each beat is checked at the falling edge of the cycle in which it is accepted: external writes when `ext_valid && ext_ready`, and local writes in the same accepting cycle. In the local-to-external direction each beat takes two extra cycles for the RAM read and capture. That gap does not matter, because the scoreboard matches beats in order rather than at fixed times. The address and length readbacks come after `busy` falls, because the registers are loaded on the same edge that clears `busy`. A hold-off `ext_ready` pattern stretches some beats to test R11.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;
   localparam logic [2:0] IDX_LOC     = 3'd0;
   localparam logic [2:0] IDX_EXT     = 3'd1;
   localparam logic [2:0] IDX_LEN_IN  = 3'd2;
   localparam logic [2:0] IDX_LEN_OUT = 3'd3;
   localparam logic [2:0] IDX_STAT    = 3'd4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LRD,
      ST_CAP,
      ST_EXT
   } st_e;
endpackage

// File: rtl/rowcopy_regs.sv
module rowcopy_regs
   import rowcopy_pkg::*;
#(
   parameter int LOC_AW = 12,
   parameter int EXT_AW = 24,
   parameter int DW     = 64,
   parameter int NBANK  = 2,
   localparam int BEAT_SH = $clog2(DW / 8),
   localparam int BANK_W  = $clog2(NBANK),
   localparam int LWW     = LOC_AW - BEAT_SH
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [2:0]                idx,
   input  logic [31:0]               wdata,
   output logic [31:0]               rdata,
   input  logic                      busy,
   input  logic                      done,
   input  logic [LWW-1:0]            fin_word,
   input  logic [EXT_AW-1:BEAT_SH]   fin_ext,
   output logic                      start,
   output logic                      dir_l2e,
   output logic [BANK_W-1:0]         bank,
   output logic [LWW-1:0]            loc_word,
   output logic [EXT_AW-1:0]         ext_base
);
   localparam int FLW = 32 - 12;
   localparam logic [FLW-1:0] LC_IDLE = FLW'((1 << LOC_AW) - (1 << BEAT_SH));

   logic                    wr_ok;
   logic [BANK_W-1:0]       bank_q;
   logic [LWW-1:0]          word_q;
   logic [EXT_AW-1:BEAT_SH] ext_q;
   logic [11:0]             skip_q;
   logic [FLW-1:0]          lc_q;

   assign wr_ok    = wr_en && !busy;
   assign start    = wr_ok && (idx == IDX_LEN_IN || idx == IDX_LEN_OUT);
   assign dir_l2e  = (idx == IDX_LEN_OUT);
   assign bank     = bank_q;
   assign loc_word = word_q;
   assign ext_base = {ext_q, {BEAT_SH{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
         word_q <= '0;
         ext_q  <= '0;
         skip_q <= '0;
         lc_q   <= '0;
      end else if (done) begin
         word_q <= fin_word;
         ext_q  <= fin_ext;
         lc_q   <= LC_IDLE;
      end else if (wr_ok) begin
         case (idx)
            IDX_LOC: begin
               word_q <= wdata[LOC_AW-1:BEAT_SH];
               bank_q <= wdata[LOC_AW +: BANK_W];
            end
            IDX_EXT: ext_q <= wdata[EXT_AW-1:BEAT_SH];
            IDX_LEN_IN, IDX_LEN_OUT: begin
               skip_q <= wdata[31:FLW];
               lc_q   <= wdata[FLW-1:0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IDX_LOC:                 rdata = 32'({bank_q, word_q, {BEAT_SH{1'b0}}});
         IDX_EXT:                 rdata = 32'({ext_q, {BEAT_SH{1'b0}}});
         IDX_LEN_IN, IDX_LEN_OUT: rdata = {skip_q, lc_q};
         IDX_STAT:                rdata = 32'(busy);
         default:                 rdata = '0;
      endcase
   end

   AST_LEN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (lc_q == LC_IDLE) && $stable(skip_q)); // R9
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(ext_q) && $stable(word_q) && $stable(bank_q) && $stable(lc_q)); // R10
endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
   import rowcopy_pkg::*;
#(
   parameter int LOC_AW = 12,
   parameter int EXT_AW = 24,
   parameter int DW     = 64,
   parameter int NBANK  = 2,
   parameter int CNT_W  = 8,
   parameter int LEN_W  = 12,
   parameter int SKIP_W = 12,
   localparam int BEAT_SH = $clog2(DW / 8),
   localparam int BANK_W  = $clog2(NBANK),
   localparam int LWW     = LOC_AW - BEAT_SH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    dir_l2e,
   input  logic [BANK_W-1:0]       start_bank,
   input  logic [LWW-1:0]          start_word,
   input  logic [EXT_AW-1:0]       start_ext,
   input  logic [31:BEAT_SH]       start_len,
   output logic                    busy,
   output logic                    done,
   output logic [LWW-1:0]          fin_word,
   output logic [EXT_AW-1:BEAT_SH] fin_ext,
   output logic [NBANK-1:0]        loc_cs,
   output logic                    loc_we,
   output logic [LWW-1:0]          loc_addr,
   output logic [DW-1:0]           loc_wdata,
   input  logic [DW-1:0]           loc_rdata,
   output logic                    ext_valid,
   input  logic                    ext_ready,
   output logic                    ext_write,
   output logic [EXT_AW-1:0]       ext_addr,
   output logic [DW-1:0]           ext_wdata,
   input  logic [DW-1:0]           ext_rdata
);
   localparam int RW = LEN_W - BEAT_SH;

   st_e               st;
   logic              dir_q;
   logic [BANK_W-1:0] bank_q;
   logic [LWW-1:0]    lw;
   logic [EXT_AW-1:0] xa;
   logic [RW-1:0]     nb_m1, bcnt;
   logic [CNT_W-1:0]  rows_q, rcnt;
   logic [SKIP_W-1:0] skip_q;
   logic [DW-1:0]     hold;
   logic              beat_ok, last_beat, last_row, loc_act;
   logic [EXT_AW-1:0] row_next;

   assign beat_ok   = (st == ST_EXT) && ext_ready;
   assign last_beat = (bcnt == nb_m1);
   assign last_row  = (rcnt == rows_q);
   assign done      = beat_ok && last_beat && last_row;
   assign busy      = (st != ST_IDLE);
   assign row_next  = xa + EXT_AW'(1 << BEAT_SH) + EXT_AW'(skip_q);
   assign fin_ext   = row_next[EXT_AW-1:BEAT_SH];
   assign fin_word  = lw + LWW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         dir_q  <= 1'b0;
         bank_q <= '0;
         lw     <= '0;
         xa     <= '0;
         nb_m1  <= '0;
         bcnt   <= '0;
         rows_q <= '0;
         rcnt   <= '0;
         skip_q <= '0;
         hold   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               dir_q  <= dir_l2e;
               bank_q <= start_bank;
               lw     <= start_word;
               xa     <= start_ext;
               nb_m1  <= start_len[LEN_W-1:BEAT_SH];
               rows_q <= start_len[LEN_W +: CNT_W];
               skip_q <= start_len[LEN_W+CNT_W +: SKIP_W];
               bcnt   <= '0;
               rcnt   <= '0;
               st     <= dir_l2e ? ST_LRD : ST_EXT;
            end
            ST_LRD: st <= ST_CAP;
            ST_CAP: begin
               hold <= loc_rdata;
               st   <= ST_EXT;
            end
            ST_EXT: if (ext_ready) begin
               lw <= lw + LWW'(1);
               if (last_beat) begin
                  bcnt <= '0;
                  xa   <= row_next;
                  rcnt <= rcnt + CNT_W'(1);
               end else begin
                  bcnt <= bcnt + RW'(1);
                  xa   <= xa + EXT_AW'(1 << BEAT_SH);
               end
               if (last_beat && last_row) st <= ST_IDLE;
               else                       st <= dir_q ? ST_LRD : ST_EXT;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign loc_act   = (st == ST_LRD) || (beat_ok && !dir_q);
   assign loc_we    = (st == ST_EXT) && !dir_q;
   assign loc_addr  = lw;
   assign loc_wdata = ext_rdata;
   assign ext_valid = (st == ST_EXT);
   assign ext_write = dir_q;
   assign ext_addr  = xa;
   assign ext_wdata = hold;

   for (genvar g = 0; g < NBANK; g++) begin : g_bank_cs
      assign loc_cs[g] = loc_act && (bank_q == BANK_W'(g));
   end

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(loc_cs)); // R7
   AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && !ext_ready) |=> ext_valid && $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_write)); // R11
   AST_LOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_ok && !done) |=> (loc_addr == $past(loc_addr) + LWW'(1))); // R7
endmodule

// File: rtl/rowcopy_dma.sv
module rowcopy_dma
   import rowcopy_pkg::*;
#(
   parameter int LOC_AW = 12,
   parameter int EXT_AW = 24,
   parameter int DW     = 64,
   parameter int NBANK  = 2,
   parameter int CNT_W  = 8,
   parameter int LEN_W  = 12,
   parameter int SKIP_W = 12,
   localparam int BEAT_SH = $clog2(DW / 8),
   localparam int BANK_W  = $clog2(NBANK),
   localparam int LWW     = LOC_AW - BEAT_SH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_idx,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              busy,
   output logic [NBANK-1:0]  loc_cs,
   output logic              loc_we,
   output logic [LWW-1:0]    loc_addr,
   output logic [DW-1:0]     loc_wdata,
   input  logic [DW-1:0]     loc_rdata,
   output logic              ext_valid,
   input  logic              ext_ready,
   output logic              ext_write,
   output logic [EXT_AW-1:0] ext_addr,
   output logic [DW-1:0]     ext_wdata,
   input  logic [DW-1:0]     ext_rdata
);
   if (LEN_W + CNT_W + SKIP_W != 32) begin : g_bad_layout
      $error("length word fields must fill 32 bits");
   end
   if (LEN_W != LOC_AW || LEN_W != 12) begin : g_bad_len
      $error("length field must span the 12-bit bank address");
   end
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_bank
      $error("bank count must be a power of two of at least 2");
   end
   if (EXT_AW <= LOC_AW || EXT_AW > 32 || LOC_AW + BANK_W > 32) begin : g_bad_aw
      $error("address widths out of range");
   end
   if (DW < 16 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("beat width must be a power of two bytes");
   end

   logic                    start, dir_l2e, done;
   logic [BANK_W-1:0]       bank;
   logic [LWW-1:0]          loc_word, fin_word;
   logic [EXT_AW-1:0]       ext_base;
   logic [EXT_AW-1:BEAT_SH] fin_ext;

   rowcopy_regs #(
      .LOC_AW(LOC_AW), .EXT_AW(EXT_AW), .DW(DW), .NBANK(NBANK)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .idx      (reg_idx),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .busy     (busy),
      .done     (done),
      .fin_word (fin_word),
      .fin_ext  (fin_ext),
      .start    (start),
      .dir_l2e  (dir_l2e),
      .bank     (bank),
      .loc_word (loc_word),
      .ext_base (ext_base)
   );

   rowcopy_seq #(
      .LOC_AW(LOC_AW), .EXT_AW(EXT_AW), .DW(DW), .NBANK(NBANK),
      .CNT_W(CNT_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .dir_l2e    (dir_l2e),
      .start_bank (bank),
      .start_word (loc_word),
      .start_ext  (ext_base),
      .start_len  (reg_wdata[31:BEAT_SH]),
      .busy       (busy),
      .done       (done),
      .fin_word   (fin_word),
      .fin_ext    (fin_ext),
      .loc_cs     (loc_cs),
      .loc_we     (loc_we),
      .loc_addr   (loc_addr),
      .loc_wdata  (loc_wdata),
      .loc_rdata  (loc_rdata),
      .ext_valid  (ext_valid),
      .ext_ready  (ext_ready),
      .ext_write  (ext_write),
      .ext_addr   (ext_addr),
      .ext_wdata  (ext_wdata),
      .ext_rdata  (ext_rdata)
   );
endmodule

// File: tb/test_rowcopy_dma.sv
module test_rowcopy_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        busy;
   logic [1:0]  loc_cs;
   logic        loc_we;
   logic [8:0]  loc_addr;
   logic [63:0] loc_wdata;
   logic [63:0] loc_rdata = '0;
   logic        ext_valid, ext_ready, ext_write;
   logic [23:0] ext_addr;
   logic [63:0] ext_wdata, ext_rdata;
   logic [3:0]  rcnt = '0;

   always #5 clk = ~clk;

   typedef struct packed {
      logic        is_loc;
      logic [23:0] addr;
      logic [63:0] data;
   } item_t;

   item_t       exp_q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [63:0] lmem [2][512];

   function automatic logic [63:0] lpat(int b, int w);
      return {16'hA5A5, 16'(b), 16'h7E00, 16'(w)};
   endfunction

   function automatic logic [63:0] epat(logic [23:0] a);
      return {8'h5A, a, 8'hC3, ~a};
   endfunction

   rowcopy_dma i_rowcopy_dma (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .loc_cs(loc_cs), .loc_we(loc_we), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
   );

   // external memory: ready stalls every fourth cycle, reads return a pattern
   always @(posedge clk) rcnt <= rcnt + 4'd1;
   assign ext_ready = (rcnt[1:0] != 2'b10);
   assign ext_rdata = epat(ext_addr);

   // local RAM model, one-cycle read latency
   always @(posedge clk) begin
      if (|loc_cs) begin
         if (loc_we) lmem[loc_cs[1]][loc_addr] <= loc_wdata;
         else        loc_rdata <= lmem[loc_cs[1]][loc_addr];
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sb_take(logic is_loc, logic [23:0] a, logic [63:0] d);
      item_t e;
      if (exp_q.size() == 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4 unexpected beat: actual %h/%h expected none", a, d);
      end else begin
         e = exp_q.pop_front();
         chk("R4 beat direction", 64'(is_loc), 64'(e.is_loc));
         chk(is_loc ? "R7 local beat address" : "R6 external beat address", 64'(a), 64'(e.addr));
         chk("R5 beat data", d, e.data);
      end
   endtask

   // monitor: compares every accepted beat against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ext_valid && ext_ready && ext_write) sb_take(1'b0, ext_addr, ext_wdata);
         if ((|loc_cs) && loc_we) sb_take(1'b1, 24'({loc_cs[1], loc_addr}), loc_wdata);
      end
   end

   task automatic reg_write(logic [2:0] i, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1;
      reg_idx = i;
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(logic [2:0] i, output logic [31:0] d);
      @(negedge clk);
      reg_idx = i;
      #1 d = reg_rdata;
   endtask

   task automatic run_xfer(bit l2e, int bank, int loc, logic [23:0] ext,
                           int len, int cnt, int skip, bit poke);
      logic [8:0]  la;
      logic [23:0] xa;
      logic [31:0] d;
      int          nb;
      int          guard;
      reg_write(3'd0, 32'((bank << 12) | loc));
      reg_write(3'd1, 32'(ext));
      nb = (len >> 3) + 1;
      la = 9'(loc >> 3);
      xa = ext;
      for (int r = 0; r <= cnt; r++) begin
         for (int b = 0; b < nb; b++) begin
            if (l2e) exp_q.push_back(item_t'{1'b0, xa, lmem[bank][la]});
            else     exp_q.push_back(item_t'{1'b1, 24'({bank[0], la}), epat(xa)});
            la = la + 9'd1;
            xa = xa + 24'd8;
         end
         xa = xa + 24'(skip);
      end
      reg_write(l2e ? 3'd3 : 3'd2, {12'(skip), 8'(cnt), 12'(len)});
      chk("R10 busy after trigger", 64'(busy), 64'd1);
      reg_read(3'd4, d);
      chk("R12 status while busy", 64'(d), 64'd1);
      if (poke) begin
         reg_write(3'd2, 32'h0000_0007);
         reg_write(3'd0, 32'h0000_0F00);
      end
      guard = 0;
      while (busy && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk("R10 busy falls", 64'(busy), 64'd0);
      repeat (12) @(negedge clk);
      chk("R5 every beat delivered", 64'(exp_q.size()), 64'd0);
      reg_read(3'd0, d);
      chk("R8 final local address", 64'(d), 64'((bank << 12) | (int'(la) << 3)));
      reg_read(3'd1, d);
      chk("R8 final external address", 64'(d), 64'(xa & 24'hFFFFF8));
      reg_read(3'd2, d);
      chk("R9 length slot 2 idle", 64'(d), 64'({12'(skip), 20'hFF8}));
      reg_read(3'd3, d);
      chk("R9 length slot 3 idle", 64'(d), 64'({12'(skip), 20'hFF8}));
      reg_read(3'd4, d);
      chk("R12 status idle", 64'(d), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 512; w++)
            lmem[b][w] = lpat(b, w);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 5; i++) begin
         reg_read(3'(i), d);
         chk("R1 reset readback", 64'(d), 64'd0);
      end
      chk("R1 reset busy", 64'(busy), 64'd0);
      chk("R1 reset port idle", 64'({loc_cs, ext_valid}), 64'd0);
      // R2 / R3 masking
      reg_write(3'd1, 32'hFFFF_FFFF);
      reg_read(3'd1, d);
      chk("R2 external mask", 64'(d), 64'h00FF_FFF8);
      reg_write(3'd0, 32'hFFFF_FFFF);
      reg_read(3'd0, d);
      chk("R3 local mask", 64'(d), 64'h0000_1FF8);
      // external to local, data bank, 2 beats x 3 rows, skip 16
      run_xfer(1'b0, 0, 12'h100, 24'h001000, 12'h00F, 2, 16, 1'b0);
      // local to external, instruction bank, 1 beat x 4 rows, writes while busy
      run_xfer(1'b1, 1, 12'h040, 24'h002000, 12'h000, 3, 8, 1'b1);
      // R7 wrap within instruction bank: 3 beats x 2 rows from word 510
      run_xfer(1'b0, 1, 12'hFF0, 24'h00A000, 12'h017, 1, 0, 1'b0);
      // R5 rounding of length 10 to 16 bytes, unaligned skip for R8 mask
      run_xfer(1'b1, 0, 12'h100, 24'h030000, 12'h009, 0, 4, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule